// File: doc/BRIEF.md
# Sticky Event Interrupt Combiner

The block gathers single-cycle event pulses from fourteen sources into a sticky status register and merges the enabled ones into one interrupt request line. Software reaches it through a small register port with four word addresses. Reading the status word returns every event latched since the last read and clears those bits in the same access. Enables are never written directly. A write-one-to-set word turns sources on and a write-one-to-clear word turns them off. A read-only mask word reports the current enables in inverted form, where a 1 marks a source that is disabled.

Status bits latch whether or not their source is enabled. The enables act only on the path to the request output. This lets software poll masked sources and take interrupts from the unmasked ones through the same status word.

Register addresses, with data bit i belonging to source i: 0 = status (read clears), 1 = enable set (write only), 2 = enable clear (write only), 3 = mask (read only, 1 = disabled). A read of a write-only address returns 0, and writes to read-only addresses are ignored.

Top module: `irq_combiner`

## Requirements
- R1: `irq_o` is 1 exactly when at least one source has both its status bit and its enable bit set; it is combinational from those registers.
- R2: A read of address 0 returns the status bits and clears them at the clock edge that ends the read, so a second read returns 0 if no new event arrived.
- R3: After reset, status is 0, every source is disabled, the mask word reads all ones (0x3FFF) and `irq_o` is 0.
- R4: A write to address 1 sets the enable of every source whose data bit is 1. A write to address 2 clears the enable of every source whose data bit is 1.
- R5: A read of address 3 returns the inverted enables, so bit i is 1 when source i is disabled.
- R6: An event that arrives in the same cycle as a status read is not lost. It is absent from that read's data and present in the next read.
- R7: An event on a disabled source still sets its status bit but does not raise `irq_o`.
- R8: Data bits that are 0 in a write to address 1 or 2 leave the corresponding enables unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register word address |
| wdata_i | input | 14 | Write data, bit i for source i |
| rdata_o | output | 14 | Read data, combinational from address and state |
| evt_i | input | 14 | Event pulses, one bit per source |
| irq_o | output | 1 | Combined interrupt request |

## Verification
An event pulse or enable write that is driven in one cycle lands at the next rising edge. After that edge, `irq_o` and the mask word show the new state at once, because they are combinational from the registers. Read data is combinational as well, so the bench captures it in the cycle of the read, before the edge that clears status. The bench drives every input at a falling edge and samples a quarter period later. Each expected value is therefore compared against register state one edge after its stimulus. The same-cycle case drives a read and an event at the same falling edge and expects the event to appear only in the following read.

// File: rtl/irq_combiner_pkg.sv
package irq_combiner_pkg;
  typedef enum logic [1:0] {
    REG_STATUS = 2'd0,
    REG_EN_SET = 2'd1,
    REG_EN_CLR = 2'd2,
    REG_MASK   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned N_SRC = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             rd_clr_i,
  output logic [N_SRC-1:0] status_o
);
  logic [N_SRC-1:0] status_q;

  // new events win over the clear of the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~{N_SRC{rd_clr_i}}) | evt_i;
  end

  assign status_o = status_q;

  AST_EVT_LATCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((status_q & $past(evt_i)) == $past(evt_i))); // R6
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_clr_i |=> ((status_q & ~$past(evt_i)) == '0)); // R2
endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank #(
  parameter int unsigned N_SRC = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_we_i,
  input  logic             clr_we_i,
  input  logic [N_SRC-1:0] bits_i,
  output logic [N_SRC-1:0] en_o
);
  logic [N_SRC-1:0] en_q;
  logic [N_SRC-1:0] set_bits, clr_bits;

  assign set_bits = set_we_i ? bits_i : '0;
  assign clr_bits = clr_we_i ? bits_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= (en_q | set_bits) & ~clr_bits;
  end

  assign en_o = en_q;

  AST_SET_ENABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_we_i && !clr_we_i) |=> ((en_q & $past(bits_i)) == $past(bits_i))); // R4
  AST_CLR_DISABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((en_q & $past(bits_i)) == '0)); // R4
  AST_ZERO_BITS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_we_i || clr_we_i) |=> ((en_q & ~$past(bits_i)) == ($past(en_q) & ~$past(bits_i)))); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_we_i || clr_we_i) |=> $stable(en_q)); // R4
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
  import irq_combiner_pkg::*;
#(
  parameter int unsigned N_SRC = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [N_SRC-1:0] wdata_i,
  output logic [N_SRC-1:0] rdata_o,
  input  logic [N_SRC-1:0] evt_i,
  output logic             irq_o
);
  logic             rd_status, wr_set, wr_clr;
  logic [N_SRC-1:0] status, en;

  assign rd_status = req_i && !we_i && (addr_i == REG_STATUS);
  assign wr_set    = req_i &&  we_i && (addr_i == REG_EN_SET);
  assign wr_clr    = req_i &&  we_i && (addr_i == REG_EN_CLR);

  irq_status_bank #(.N_SRC(N_SRC)) status_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt_i),
    .rd_clr_i (rd_status),
    .status_o (status)
  );

  irq_enable_bank #(.N_SRC(N_SRC)) enable_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_we_i (wr_set),
    .clr_we_i (wr_clr),
    .bits_i   (wdata_i),
    .en_o     (en)
  );

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      unique case (addr_i)
        REG_STATUS: rdata_o = status;
        REG_MASK:   rdata_o = ~en;
        default:    rdata_o = '0;
      endcase
    end
  end

  assign irq_o = |(status & en);

  AST_NO_EN_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en == '0) |-> !irq_o); // R7
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_status) && ($past(evt_i) == '0) |-> !irq_o); // R1
endmodule

// File: tb/irq_combiner_tb_top.sv
module irq_combiner_tb_top;
  localparam int N = 14;
  localparam logic [N-1:0] ALL = '1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req = 1'b0, we = 1'b0;
  logic [1:0]   addr = '0;
  logic [N-1:0] wdata = '0, rdata, evt = '0;
  logic         irq;
  int           n_chk = 0, n_bad = 0;
  logic [N-1:0] rv;

  always #10 clk = ~clk;

  irq_combiner #(.N_SRC(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    #5 d = rdata;
    @(negedge clk); req = 0;
  endtask

  task automatic pulse(input logic [N-1:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = '0;
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #5 check("R3 irq after reset", N'(irq), '0);
    rd(2'd3, rv); check("R3 mask after reset", rv, ALL);
    rd(2'd0, rv); check("R3 status after reset", rv, '0);

    for (int i = 0; i < N; i++) begin
      logic [N-1:0] b;
      b = N'(1) << i;
      pulse(b);
      #5 check("R7 masked event no irq", N'(irq), '0);
      rd(2'd0, rv); check("R7 masked event latched", rv, b);
      rd(2'd0, rv); check("R2 status cleared by read", rv, '0);
      wr(2'd1, b);
      rd(2'd3, rv); check("R5 mask shows enable", rv, ~b);
      #5 check("R1 enabled without status", N'(irq), '0);
      pulse(b);
      #5 check("R1 enabled event raises irq", N'(irq), 1);
      rd(2'd0, rv); check("R2 read returns event", rv, b);
      #5 check("R1 irq drops after clear", N'(irq), '0);
      wr(2'd2, b);
      rd(2'd3, rv); check("R4 disable restores mask", rv, ALL);
    end

    wr(2'd1, 14'h00FF);
    wr(2'd1, 14'h0100);
    rd(2'd3, rv); check("R8 set keeps zero bits", rv, ~14'h01FF);
    wr(2'd2, 14'h0001);
    rd(2'd3, rv); check("R8 clear keeps zero bits", rv, ~14'h01FE);
    wr(2'd2, ALL);
    rd(2'd3, rv); check("R4 clear all", rv, ALL);

    // event coincident with status read
    @(negedge clk); req = 1; we = 0; addr = 2'd0; evt = 14'h0020;
    #5 rv = rdata;
    @(negedge clk); req = 0; evt = '0;
    check("R6 same-cycle event not in read", rv, '0);
    rd(2'd0, rv); check("R6 same-cycle event kept", rv, 14'h0020);

    wr(2'd1, 14'h0003);
    pulse(14'h2000);
    #5 check("R1 disabled source alone", N'(irq), '0);
    pulse(14'h0002);
    #5 check("R1 OR of enabled sources", N'(irq), 1);
    rd(2'd0, rv); check("R7 both latched", rv, 14'h2002);
    rd(2'd1, rv); check("R5 write-only reads zero", rv, '0);
    wr(2'd3, '0);
    rd(2'd3, rv); check("R5 mask not writable", rv, ~14'h0003);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule